// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets a clocked host reach an external asynchronous static RAM of 256K words by 32 bits. The RAM has 18 address pins, a 32-bit data bus used in both directions, two active-low chip enables (one per 16-bit half of the word), four active-low byte selects, one write strobe and one output enable. The host side is a single-request valid/ready port that carries an address, a write flag, a byte mask and write data. Read results come back on a data output with a one-clock valid pulse.

The data bus is split into an output value, a drive enable and an input value, so the pad ring can build the tristate buffer. A mode input selects one of two views of the part. The word view gives 256K locations of 32 bits. The halfword view gives 512K locations of 16 bits: the lowest host address bit picks which chip enable is pulled low.

The write strobe width and the read access width are parameters counted in controller clocks. One design can therefore meet any speed grade at a given clock rate. The defaults give 12 ns and 16 ns at a 4 ns clock. The controller handles one request at a time.

Top module: `asram_ctrl`

## Requirements
- R1: After reset and while idle, `req_ready` is 1, both chip enables, all byte selects, `mem_we_n` and `mem_oe_n` are 1, and `mem_dq_oe` and `rsp_valid` are 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. All request fields and `cfg_half16` are captured at that edge, and later changes have no effect. `req_ready` then stays 0 for WR_CYC+1 cycles after a write, or RD_CYC+1 cycles after a read.
- R3: A write holds `mem_we_n` low for exactly WR_CYC consecutive cycles. During those cycles the address, chip enables, byte selects and `mem_dq_o` do not change. `mem_dq_oe` is 1 during those cycles and for exactly one guard cycle after them (with `mem_we_n` high), and 0 at all other times.
- R4: A read begins with one turnaround cycle in which the chip enables and byte selects are active, `mem_oe_n` is 1 and `mem_dq_oe` is 0. It then holds `mem_oe_n` low for exactly RD_CYC cycles. `mem_we_n` stays 1 for the whole read.
- R5: `rsp_valid` is 1 for exactly one clock, in the cycle right after the last cycle with `mem_oe_n` low. In that cycle `rsp_rdata` holds the bus value sampled at the end of that last cycle. A write never raises `rsp_valid`.
- R6: In word view (`cfg_half16`=0), `mem_addr` equals `req_addr[17:0]` and both chip enables go low. On a write, byte select i is the inverse of `req_mask[i]`, where lane i is data bits 8i+7..8i. A read pulls all four byte selects low and returns the full word.
- R7: In halfword view (`cfg_half16`=1), `mem_addr` equals `req_addr[18:1]`. `req_addr[0]`=0 selects chip enable 0, byte selects 1..0 and data bits 15..0. `req_addr[0]`=1 selects chip enable 1, byte selects 3..2 and data bits 31..16. The chip enable and byte selects of the other half stay 1.
- R8: A halfword write puts `req_wdata[15:0]` on the data bits of the selected half. `req_mask[1:0]` maps to the lower and upper byte selects of that half, and `req_mask[3:2]` is ignored.
- R9: A halfword read returns the selected half in `rsp_rdata[15:0]` with `rsp_rdata[31:16]` zero.
- R10: `mem_we_n` and `mem_oe_n` are never low in the same cycle, and `mem_dq_oe` is never 1 while `mem_oe_n` is low.
- R11: A write with an all-zero mask leaves every byte select high and the memory contents unchanged, while still running the full write sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_half16 | input | 1 | 1 selects the 512K x 16 view, 0 the 256K x 32 view |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | ADDR_W+1 (19) | Word address (bits 17..0) or halfword address (bits 18..0) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_mask | input | LANES (4) | Byte write mask, active high |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | One-clock read data valid |
| rsp_rdata | output | DATA_W (32) | Read data |
| mem_addr | output | ADDR_W (18) | RAM address pins |
| mem_ce_n | output | 2 | Active-low chip enables, bit h for data half h |
| mem_bs_n | output | LANES (4) | Active-low byte selects |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_o | output | DATA_W (32) | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_i | input | DATA_W (32) | Data returned from the RAM |

## Verification
Full-word writes and reads with alternating and walking patterns check the basic word path and the strobe and access widths. Partial-mask writes over a known background show that each byte select reaches its own lane. An all-zero mask shows that a write can run to completion without touching any byte. Halfword traffic to both halves of one word, read back in both views, shows that the low address bit steers the correct chip enable and data half. A halfword mask shows that only the two low mask bits matter. Requests at the top address, requests issued back to back, and mode and field changes made while a request is in progress check address decoding and the capture of fields at acceptance.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_WSTROBE = 3'd1,
    PH_WGUARD  = 3'd2,
    PH_RTURN   = 3'd3,
    PH_RACCESS = 3'd4
  } phase_t;

  // Width of a down-counter able to hold the longer of two phase lengths.
  function automatic int unsigned f_cnt_width(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    if (m < 1) m = 1;
    return $clog2(m + 1);
  endfunction

  // Half of the data word targeted by a halfword access.
  function automatic logic f_half_pick(input logic half_mode, input logic addr_lsb,
                                       input int unsigned half_idx);
    return !half_mode || (addr_lsb == half_idx[0]);
  endfunction

endpackage

// File: rtl/sramc_seq.sv
module sramc_seq
  import sramc_pkg::*;
#(
  parameter int unsigned WR_CYC = 3,
  parameter int unsigned RD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_wr,
  output logic idle,
  output logic sel_active,
  output logic we_n,
  output logic oe_n,
  output logic drive,
  output logic sample_now
);

  localparam int unsigned CW = f_cnt_width(WR_CYC, RD_CYC);
  localparam logic [CW-1:0] WR_LOAD = CW'(WR_CYC - 1);
  localparam logic [CW-1:0] RD_LOAD = CW'(RD_CYC - 1);

  phase_t phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    phase_d    = phase_q;
    cnt_d      = cnt_q;
    sample_now = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          if (start_wr) begin
            phase_d = PH_WSTROBE;
            cnt_d   = WR_LOAD;
          end else begin
            phase_d = PH_RTURN;
          end
        end
      end
      PH_WSTROBE: begin
        if (cnt_zero) phase_d = PH_WGUARD;
        else          cnt_d   = cnt_q - CW'(1);
      end
      PH_WGUARD: phase_d = PH_IDLE;
      PH_RTURN: begin
        phase_d = PH_RACCESS;
        cnt_d   = RD_LOAD;
      end
      PH_RACCESS: begin
        if (cnt_zero) begin
          phase_d    = PH_IDLE;
          sample_now = 1'b1;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  // Named phase events, decoded straight from the phase register.
  assign idle       = (phase_q == PH_IDLE);
  assign sel_active = (phase_q == PH_WSTROBE) || (phase_q == PH_RTURN) ||
                      (phase_q == PH_RACCESS);
  assign we_n       = (phase_q != PH_WSTROBE);
  assign oe_n       = (phase_q != PH_RACCESS);
  assign drive      = (phase_q == PH_WSTROBE) || (phase_q == PH_WGUARD);

  // Checker: length of the current strobe or access run, counted separately.
  logic [CW:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (phase_q == PH_WSTROBE || phase_q == PH_RACCESS) run_q <= run_q + (CW+1)'(1);
    else run_q <= '0;
  end

  assert_strobe_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WGUARD) |-> (run_q == (CW+1)'(WR_CYC)));

  assert_access_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_now |-> (run_q == (CW+1)'(RD_CYC - 1)));

  assert_guard_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WGUARD) |=> idle);

endmodule

// File: rtl/sramc_lanemap.sv
module sramc_lanemap
  import sramc_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                      half_mode,
  input  logic [ADDR_W:0]           host_addr,
  input  logic [LANES-1:0]          mask,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic [LANES*LANE_W-1:0]   dq_in,
  input  logic                      is_write,
  input  logic                      sel_active,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [1:0]                ce_n,
  output logic [LANES-1:0]          bs_n,
  output logic [LANES*LANE_W-1:0]   dq_out,
  output logic [LANES*LANE_W-1:0]   rdata
);

  localparam int unsigned HL = LANES / 2;

  logic addr_lsb;
  assign addr_lsb = host_addr[0];
  assign mem_addr = half_mode ? host_addr[ADDR_W:1] : host_addr[ADDR_W-1:0];

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign ce_n[h] = !(sel_active && f_half_pick(half_mode, addr_lsb, h));
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int unsigned H = i / HL;
    localparam int unsigned J = i % HL;
    logic lane_en;
    assign lane_en = is_write ? (half_mode ? mask[J] : mask[i]) : 1'b1;
    assign bs_n[i] = !(sel_active && f_half_pick(half_mode, addr_lsb, H) && lane_en);
    assign dq_out[i*LANE_W +: LANE_W] = half_mode ? wdata[J*LANE_W +: LANE_W]
                                                  : wdata[i*LANE_W +: LANE_W];
    if (i < HL) begin : g_low
      assign rdata[i*LANE_W +: LANE_W] =
        (half_mode && addr_lsb) ? dq_in[(i+HL)*LANE_W +: LANE_W]
                                : dq_in[i*LANE_W +: LANE_W];
    end else begin : g_high
      assign rdata[i*LANE_W +: LANE_W] = half_mode ? '0 : dq_in[i*LANE_W +: LANE_W];
    end
  end

  always_comb begin
    if (!sel_active) begin
      assert_idle_quiet_R1: assert (ce_n == 2'b11 && bs_n == '1);
    end
    if (sel_active && half_mode) begin
      assert_one_half_R7: assert ($countones(~ce_n) == 1);
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned WR_CYC = 3,
  parameter int unsigned RD_CYC = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_half16,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W:0]          req_addr,
  input  logic                     req_write,
  input  logic [LANES-1:0]         req_mask,
  input  logic [LANES*LANE_W-1:0]  req_wdata,
  output logic                     rsp_valid,
  output logic [LANES*LANE_W-1:0]  rsp_rdata,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [1:0]               mem_ce_n,
  output logic [LANES-1:0]         mem_bs_n,
  output logic                     mem_we_n,
  output logic                     mem_oe_n,
  output logic [LANES*LANE_W-1:0]  mem_dq_o,
  output logic                     mem_dq_oe,
  input  logic [LANES*LANE_W-1:0]  mem_dq_i
);

  localparam int unsigned DATA_W = LANES * LANE_W;

  logic idle, sel_active, sample_now, accept;
  logic mode_q, wr_q;
  logic [ADDR_W:0] addr_q;
  logic [LANES-1:0] mask_q;
  logic [DATA_W-1:0] wdata_q, map_rdata;

  assign accept    = req_valid && idle;
  assign req_ready = idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      mask_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      mode_q  <= cfg_half16;
      wr_q    <= req_write;
      addr_q  <= req_addr;
      mask_q  <= req_mask;
      wdata_q <= req_wdata;
    end
  end

  sramc_seq #(.WR_CYC(WR_CYC), .RD_CYC(RD_CYC)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_wr   (req_write),
    .idle       (idle),
    .sel_active (sel_active),
    .we_n       (mem_we_n),
    .oe_n       (mem_oe_n),
    .drive      (mem_dq_oe),
    .sample_now (sample_now)
  );

  sramc_lanemap #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) map_i (
    .half_mode  (mode_q),
    .host_addr  (addr_q),
    .mask       (mask_q),
    .wdata      (wdata_q),
    .dq_in      (mem_dq_i),
    .is_write   (wr_q),
    .sel_active (sel_active),
    .mem_addr   (mem_addr),
    .ce_n       (mem_ce_n),
    .bs_n       (mem_bs_n),
    .dq_out     (mem_dq_o),
    .rdata      (map_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= sample_now;
      if (sample_now) rsp_rdata <= map_rdata;
    end
  end

  assert_excl_strobes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  assert_no_drive_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_hold_in_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |->
      ($stable(mem_addr) && $stable(mem_ce_n) && $stable(mem_bs_n) && $stable(mem_dq_o)));

  assert_guard_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  assert_guard_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && mem_we_n) |=> !mem_dq_oe);

  assert_turn_before_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> (!$past(mem_dq_oe) && ($past(mem_ce_n) != 2'b11)));

  assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_rsp_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !$past(mem_oe_n));

  assert_single_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && mem_ce_n != 2'b11) |-> ($countones(mem_ce_n) == 1));

endmodule

// File: tb/asram_ctrl_tb_top.sv
module asram_ctrl_tb_top;

  localparam int unsigned WR = 3;
  localparam int unsigned RD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_half16 = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [18:0] req_addr = '0;
  logic req_write = 1'b0;
  logic [3:0] req_mask = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [17:0] mem_addr;
  logic [1:0] mem_ce_n;
  logic [3:0] mem_bs_n;
  logic mem_we_n, mem_oe_n, mem_dq_oe;
  logic [31:0] mem_dq_o;
  logic [31:0] mem_dq_i = '0;

  int checks = 0;
  int fails = 0;

  logic [31:0] model_mem [int unsigned];
  logic [31:0] ref_mem [int unsigned];

  always #2 clk = ~clk;

  asram_ctrl #(.WR_CYC(WR), .RD_CYC(RD)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_half16(cfg_half16),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_mask(req_mask), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_bs_n(mem_bs_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // RAM model: pins are stable at the falling edge.
  always @(negedge clk) begin
    logic [31:0] w;
    int unsigned a;
    a = {14'd0, mem_addr};
    w = model_mem.exists(a) ? model_mem[a] : 32'h0;
    if (!mem_we_n) begin
      for (int i = 0; i < 4; i++)
        if (!mem_ce_n[i/2] && !mem_bs_n[i]) w[8*i +: 8] = mem_dq_o[8*i +: 8];
      model_mem[a] = w;
      chk(mem_dq_oe == 1'b1, "R3", "drive during strobe", {31'd0, mem_dq_oe}, 32'd1);
    end
    for (int i = 0; i < 4; i++)
      mem_dq_i[8*i +: 8] = (!mem_ce_n[i/2] && mem_we_n && !mem_oe_n && !mem_bs_n[i])
                           ? w[8*i +: 8] : 8'hEE;
    if (rst_n && (!mem_oe_n)) begin
      chk(mem_we_n && !mem_dq_oe, "R10", "oe overlap",
          {30'd0, mem_we_n, mem_dq_oe}, 32'd2);
    end
  end

  function automatic logic [1:0] exp_ce(input bit half, input logic [18:0] a);
    return half ? (a[0] ? 2'b01 : 2'b10) : 2'b00;
  endfunction

  function automatic logic [3:0] exp_bs(input bit half, input bit wr,
                                        input logic [18:0] a, input logic [3:0] m);
    logic [3:0] en;
    if (half) en = a[0] ? {(wr ? m[1:0] : 2'b11), 2'b00} : {2'b00, (wr ? m[1:0] : 2'b11)};
    else      en = wr ? m : 4'hF;
    return ~en;
  endfunction

  function automatic logic [17:0] exp_addr(input bit half, input logic [18:0] a);
    return half ? a[18:1] : a[17:0];
  endfunction

  task automatic issue(input bit half, input logic [18:0] a, input bit wr,
                       input logic [3:0] m, input logic [31:0] d);
    chk(req_ready == 1'b1, "R2", "ready before issue", {31'd0, req_ready}, 32'd1);
    cfg_half16 = half; req_valid = 1'b1; req_addr = a; req_write = wr;
    req_mask = m; req_wdata = d;
    @(posedge clk);
    #1;
    // Disturb every field while busy: captured values must rule (R2).
    req_valid = 1'b0; cfg_half16 = !half; req_addr = ~a; req_write = !wr;
    req_mask = ~m; req_wdata = ~d;
    @(negedge clk);
  endtask

  task automatic do_write(input bit half, input logic [18:0] a, input logic [3:0] m,
                          input logic [31:0] d, input string tag);
    int unsigned word;
    logic [31:0] w;
    int busy, we_cnt, drv;
    bit pin_ok, rv;
    word = half ? {13'd0, a[18:1]} : {14'd0, a[17:0]};
    w = ref_mem.exists(word) ? ref_mem[word] : 32'h0;
    for (int j = 0; j < 4; j++) begin
      if (half) begin
        if (j < 2 && m[j]) w[8*(j + 2*a[0]) +: 8] = d[8*j +: 8];
      end else if (m[j]) begin
        w[8*j +: 8] = d[8*j +: 8];
      end
    end
    ref_mem[word] = w;
    issue(half, a, 1'b1, m, d);
    busy = 0; we_cnt = 0; drv = 0; pin_ok = 1'b1; rv = 1'b0;
    while (!req_ready && busy < 50) begin
      busy++;
      if (!mem_we_n) begin
        we_cnt++;
        if (mem_addr != exp_addr(half, a) || mem_ce_n != exp_ce(half, a) ||
            mem_bs_n != exp_bs(half, 1'b1, a, m)) pin_ok = 1'b0;
        if (half && mem_dq_o[16*a[0] +: 16] != d[15:0]) pin_ok = 1'b0;
        if (!half && mem_dq_o != d) pin_ok = 1'b0;
      end
      if (mem_dq_oe) drv++;
      if (rsp_valid) rv = 1'b1;
      @(negedge clk);
    end
    chk(busy == WR + 1, "R2", {tag, " write busy"}, busy, WR + 1);
    chk(we_cnt == WR, "R3", {tag, " strobe width"}, we_cnt, WR);
    chk(drv == WR + 1, "R3", {tag, " drive cycles"}, drv, WR + 1);
    chk(pin_ok, half ? "R7/R8" : "R6", {tag, " write pins"}, {28'd0, mem_bs_n}, {28'd0, exp_bs(half, 1'b1, a, m)});
    chk(!rv, "R5", {tag, " no rsp on write"}, {31'd0, rv}, 32'd0);
  endtask

  task automatic do_read(input bit half, input logic [18:0] a, input string tag);
    int unsigned word;
    logic [31:0] w, e;
    int busy, oe_cnt;
    bit turn_ok, pin_ok, first;
    word = half ? {13'd0, a[18:1]} : {14'd0, a[17:0]};
    w = ref_mem.exists(word) ? ref_mem[word] : 32'h0;
    e = half ? {16'h0, (a[0] ? w[31:16] : w[15:0])} : w;
    issue(half, a, 1'b0, 4'h0, 32'h0);
    busy = 0; oe_cnt = 0; turn_ok = 1'b0; pin_ok = 1'b1; first = 1'b1;
    while (!req_ready && busy < 50) begin
      busy++;
      if (first)
        turn_ok = mem_oe_n && !mem_dq_oe && mem_ce_n == exp_ce(half, a) &&
                  mem_bs_n == exp_bs(half, 1'b0, a, 4'h0) && mem_addr == exp_addr(half, a);
      first = 1'b0;
      if (!mem_oe_n) begin
        oe_cnt++;
        if (mem_ce_n != exp_ce(half, a) || mem_bs_n != exp_bs(half, 1'b0, a, 4'h0) ||
            mem_addr != exp_addr(half, a)) pin_ok = 1'b0;
      end
      if (!mem_we_n || mem_dq_oe) pin_ok = 1'b0;
      @(negedge clk);
    end
    chk(busy == RD + 1, "R2", {tag, " read busy"}, busy, RD + 1);
    chk(oe_cnt == RD, "R4", {tag, " access width"}, oe_cnt, RD);
    chk(turn_ok, "R4", {tag, " turnaround"}, {31'd0, turn_ok}, 32'd1);
    chk(pin_ok, half ? "R7" : "R6", {tag, " read pins"}, {28'd0, mem_bs_n}, {28'd0, exp_bs(half, 1'b0, a, 4'h0)});
    chk(rsp_valid == 1'b1, "R5", {tag, " rsp pulse"}, {31'd0, rsp_valid}, 32'd1);
    chk(rsp_rdata == e, half ? "R9" : "R6", {tag, " read data"}, rsp_rdata, e);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R5", {tag, " rsp one clock"}, {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_reset;
    logic [9:0] pins;
    pins = {mem_ce_n, mem_bs_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid};
    chk(pins == 10'b11_1111_1_1_0_0, "R1", "pins in reset", {22'd0, pins}, {22'd0, 10'b11_1111_1_1_0_0});
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    pins = {mem_ce_n, mem_bs_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid};
    chk(pins == 10'b11_1111_1_1_0_0 && req_ready, "R1", "pins idle",
        {21'd0, req_ready, pins}, {21'd0, 1'b1, 10'b11_1111_1_1_0_0});
  endtask

  task automatic t_full_words;
    do_write(1'b0, 19'h00010, 4'hF, 32'hA5A5_5A5A, "R6 word a");
    do_write(1'b0, 19'h00011, 4'hF, 32'h0123_4567, "R6 word b");
    do_read (1'b0, 19'h00010, "R6 word a");
    do_read (1'b0, 19'h00011, "R6 word b");
    for (int k = 0; k < 4; k++) begin
      do_write(1'b0, 19'h00100 + 19'(k), 4'hF, 32'h1 << (8*k + k), "R6 walk");
      do_read (1'b0, 19'h00100 + 19'(k), "R6 walk");
    end
  endtask

  task automatic t_byte_mask;
    do_write(1'b0, 19'h00020, 4'hF, 32'hFFFF_FFFF, "R6 bg");
    do_write(1'b0, 19'h00020, 4'b0101, 32'h0000_0000, "R6 mask0101");
    do_read (1'b0, 19'h00020, "R6 mask0101");
    do_write(1'b0, 19'h00020, 4'b1000, 32'h1200_0000, "R6 mask1000");
    do_read (1'b0, 19'h00020, "R6 mask1000");
  endtask

  task automatic t_zero_mask;
    do_write(1'b0, 19'h00030, 4'hF, 32'hCAFE_F00D, "R11 bg");
    do_write(1'b0, 19'h00030, 4'h0, 32'h1111_1111, "R11 zero mask");
    do_read (1'b0, 19'h00030, "R11 unchanged");
  endtask

  task automatic t_half_mode;
    do_write(1'b1, 19'h00080, 4'h3, 32'hDEAD_BEEF, "R8 low half");
    do_write(1'b1, 19'h00081, 4'h3, 32'h0000_7744, "R8 high half");
    do_read (1'b1, 19'h00080, "R9 low half");
    do_read (1'b1, 19'h00081, "R9 high half");
    do_read (1'b0, 19'h00040, "R7 word view of halves");
  endtask

  task automatic t_half_mask;
    do_write(1'b1, 19'h00091, 4'b1110, 32'h0000_9900, "R8 upper byte only");
    do_read (1'b1, 19'h00091, "R8 upper byte only");
    do_write(1'b1, 19'h00090, 4'b1101, 32'h0000_00C3, "R8 lower byte only");
    do_read (1'b0, 19'h00048, "R8 word after halfword masks");
  endtask

  task automatic t_top_addr;
    do_write(1'b0, 19'h3FFFF, 4'hF, 32'h8765_4321, "R6 top word");
    do_read (1'b0, 19'h3FFFF, "R6 top word");
    do_write(1'b1, 19'h7FFFF, 4'h3, 32'h0000_ABCD, "R7 top halfword");
    do_read (1'b1, 19'h7FFFF, "R7 top halfword");
    do_read (1'b0, 19'h3FFFF, "R7 top word merged");
  endtask

  task automatic t_back_to_back;
    do_write(1'b0, 19'h00200, 4'hF, 32'h5555_AAAA, "R2 b2b");
    do_write(1'b1, 19'h00401, 4'h3, 32'h0000_3C3C, "R2 b2b");
    do_read (1'b0, 19'h00200, "R2 b2b");
    do_read (1'b1, 19'h00401, "R2 b2b");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_full_words();
    t_byte_mask();
    t_zero_mask();
    t_half_mode();
    t_half_mask();
    t_top_addr();
    t_back_to_back();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule